// File: doc/BRIEF.md
# Multicast Hash Receive Filter

This block decides, for each incoming Ethernet frame, whether the receiver keeps it. It observes only the destination address, which arrives one byte per qualified cycle. The first byte is marked by a start strobe. The block checks the destination against the station's own unicast address. A multicast destination is checked against a 64-entry bitmap. The bitmap is indexed by six bits of a CRC-32 that the block folds over the six address bytes while they stream in.

Three mode inputs control the outcome. Promiscuous mode accepts everything. Accept-all-multicast mode admits every group address whatever the bitmap holds. Hashed-multicast mode uses the bitmap lookup. The broadcast address is always accepted. The block samples the modes, the station address and the bitmap at the frame start, so software may rewrite them at any time without corrupting a frame in flight. The result is one registered accept bit qualified by a single-cycle valid pulse.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, and until the first frame completes, `dec_vld` and `dec_accept` are 0.
- R2: Each frame produces exactly one `dec_vld` pulse, one cycle long. It appears in the cycle after the clock edge that takes the sixth address byte. `dec_accept` is 0 whenever `dec_vld` is 0.
- R3: A byte is taken on a clock edge where `byte_vld` is 1. Cycles where `byte_vld` is 0 do not advance the frame. The first byte is address byte 0 and is compared with `station_addr[47:40]`; byte 5 is compared with `station_addr[7:0]`. With promiscuous mode off, a unicast frame is accepted only when all 48 bits match.
- R4: A destination is multicast when bit 0 of address byte 0 is 1. The CRC starts at 0xFFFFFFFF and uses polynomial 0x04C11DB7. Each byte is fed least significant bit first, by shifting left and XORing the polynomial when the outgoing bit 31 differs from the data bit. No final inversion is applied. The index is CRC bits [31:26], and it selects `hash_table[index]`. With hashed mode on and the other two modes off, a non-broadcast multicast frame is accepted exactly when that bit is 1.
- R5: With accept-all-multicast on, every multicast frame is accepted, even if the bitmap is all zeros.
- R6: With promiscuous mode on, every frame is accepted.
- R7: The all-ones destination is accepted even with all modes off and an all-zero bitmap.
- R8: With promiscuous, accept-all-multicast and hashed modes all off, a non-broadcast multicast frame is rejected, even if the bitmap is all ones.
- R9: The modes, station address and bitmap in force when the start byte is taken decide the frame. Changes made later in that frame have no effect on its decision.
- R10: Bytes qualified without a start strobe are ignored, whether they come before any frame or after the sixth byte. A start strobe in the middle of a frame abandons that frame; only the new frame is decided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Marks the qualified byte as address byte 0 |
| byte_vld | input | 1 | Qualifies `byte_data` this cycle |
| byte_data | input | 8 | Destination address byte |
| mode_promisc | input | 1 | Accept every frame |
| mode_all_mc | input | 1 | Accept every multicast frame |
| mode_hash_mc | input | 1 | Accept multicast frames whose hash bit is set |
| station_addr | input | 48 | Own unicast address, byte 0 in bits [47:40] |
| hash_table | input | 64 | Multicast hash bitmap, bit n for index n |
| dec_vld | output | 1 | One-cycle pulse: decision valid |
| dec_accept | output | 1 | 1 to keep the frame, 0 to drop it |

## Verification
The hardest situation to reach from the ports is full coverage of the bitmap. A given bit is selected only when the CRC of a chosen address happens to land on that index. The bench therefore draws pseudo-random group addresses and computes each CRC arithmetically. It keeps drawing until every one of the 64 indices has been hit. For each draw it sends the frame twice: once with only the selected bit set, and once with every bit except it.

Mid-frame register changes, restarts and stray bytes are produced by driving the byte stream directly. Configuration is flipped right after the start byte, and partial frames are abandoned.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

   // one byte folded into a left-shifting CRC register, data bit 0 first
   function automatic logic [31:0] crc_fold_lsb(input logic [31:0] c_in,
                                                input logic [7:0]  d,
                                                input logic [31:0] poly);
      logic [31:0] c;
      logic        fb;
      c = c_in;
      for (int b = 0; b < 8; b++) begin
         fb = c[31] ^ d[b];
         c  = {c[30:0], 1'b0} ^ (fb ? poly : 32'd0);
      end
      return c;
   endfunction

   // same fold with data bit 7 first
   function automatic logic [31:0] crc_fold_msb(input logic [31:0] c_in,
                                                input logic [7:0]  d,
                                                input logic [31:0] poly);
      logic [31:0] c;
      logic        fb;
      c = c_in;
      for (int b = 7; b >= 0; b--) begin
         fb = c[31] ^ d[b];
         c  = {c[30:0], 1'b0} ^ (fb ? poly : 32'd0);
      end
      return c;
   endfunction

endpackage

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine #(
   parameter logic [31:0] POLY      = 32'h04C1_1DB7,
   parameter logic [31:0] INIT      = 32'hFFFF_FFFF,
   parameter bit          LSB_FIRST = 1'b1,
   parameter int          OUT_BITS  = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic                step,
   input  logic [7:0]          din,
   output logic [OUT_BITS-1:0] top_bits
);
   import mhf_pkg::*;

   logic [31:0] crc_q;
   logic [31:0] seed;
   logic [31:0] crc_nxt;

   assign seed = restart ? INIT : crc_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign crc_nxt = crc_fold_lsb(seed, din, POLY);
      end else begin : g_msb
         assign crc_nxt = crc_fold_msb(seed, din, POLY);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc_q <= INIT;
      else if (step) crc_q <= crc_nxt;
   end

   assign top_bits = crc_nxt[31 -: OUT_BITS];

endmodule

// File: rtl/mhf_frame_tracker.sv
module mhf_frame_tracker #(
   parameter int ADDR_BYTES = 6,
   parameter int CFG_W      = 115
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sof,
   input  logic                    byte_vld,
   input  logic [7:0]              byte_data,
   input  logic [CFG_W-1:0]        cfg_in,
   output logic                    take,
   output logic                    restart,
   output logic                    last,
   output logic [8*ADDR_BYTES-1:0] addr_nxt,
   output logic [CFG_W-1:0]        cfg_q
);
   localparam int ADDR_W = 8 * ADDR_BYTES;
   localparam int CW     = $clog2(ADDR_BYTES + 1);

   logic [CW-1:0]     cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic              busy;

   assign busy     = (cnt_q != '0) && (cnt_q < CW'(ADDR_BYTES));
   assign take     = byte_vld & (sof | busy);
   assign restart  = byte_vld & sof;
   assign last     = take & ~sof & (cnt_q == CW'(ADDR_BYTES - 1));
   assign addr_nxt = {addr_q[ADDR_W-9:0], byte_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         addr_q <= '0;
         cfg_q  <= '0;
      end else begin
         if (take) begin
            cnt_q  <= sof ? CW'(1) : cnt_q + CW'(1);
            addr_q <= addr_nxt;
         end
         if (restart) cfg_q <= cfg_in;
      end
   end

endmodule

// File: rtl/mhf_verdict.sv
module mhf_verdict #(
   parameter int ADDR_W    = 48,
   parameter int HASH_BITS = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    last,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [HASH_BITS-1:0]    hash_idx,
   input  logic                    promisc,
   input  logic                    all_mc,
   input  logic                    hash_mc,
   input  logic [ADDR_W-1:0]       station,
   input  logic [(1<<HASH_BITS)-1:0] table_bits,
   output logic                    dec_vld,
   output logic                    dec_accept
);
   logic is_group;
   logic is_bcast;
   logic hit;
   logic own;
   logic keep;

   assign is_group = addr[ADDR_W-8];
   assign is_bcast = &addr;
   assign hit      = table_bits[hash_idx];
   assign own      = (addr == station);
   assign keep     = promisc | is_bcast |
                     (is_group ? (all_mc | (hash_mc & hit)) : own);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_vld    <= 1'b0;
         dec_accept <= 1'b0;
      end else begin
         dec_vld    <= last;
         dec_accept <= last & keep;
      end
   end

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
   parameter int          ADDR_BYTES = 6,
   parameter int          HASH_BITS  = 6,
   parameter logic [31:0] CRC_POLY   = 32'h04C1_1DB7,
   parameter logic [31:0] CRC_INIT   = 32'hFFFF_FFFF,
   parameter bit          LSB_FIRST  = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        sof,
   input  logic                        byte_vld,
   input  logic [7:0]                  byte_data,
   input  logic                        mode_promisc,
   input  logic                        mode_all_mc,
   input  logic                        mode_hash_mc,
   input  logic [8*ADDR_BYTES-1:0]     station_addr,
   input  logic [(1<<HASH_BITS)-1:0]   hash_table,
   output logic                        dec_vld,
   output logic                        dec_accept
);
   localparam int ADDR_W  = 8 * ADDR_BYTES;
   localparam int TABLE_N = 1 << HASH_BITS;
   localparam int CFG_W   = 3 + ADDR_W + TABLE_N;

   generate
      if (ADDR_BYTES < 2) begin : g_chk_bytes
         $error("mcast_hash_filter: ADDR_BYTES must be at least 2");
      end
      if (HASH_BITS < 1 || HASH_BITS > 8) begin : g_chk_hash
         $error("mcast_hash_filter: HASH_BITS must lie in 1..8");
      end
   endgenerate

   logic                 take;
   logic                 restart;
   logic                 last;
   logic [ADDR_W-1:0]    addr_nxt;
   logic [CFG_W-1:0]     cfg_in;
   logic [CFG_W-1:0]     cfg_q;
   logic [HASH_BITS-1:0] hash_idx;

   assign cfg_in = {mode_promisc, mode_all_mc, mode_hash_mc, station_addr, hash_table};

   mhf_frame_tracker #(
      .ADDR_BYTES (ADDR_BYTES),
      .CFG_W      (CFG_W)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof       (sof),
      .byte_vld  (byte_vld),
      .byte_data (byte_data),
      .cfg_in    (cfg_in),
      .take      (take),
      .restart   (restart),
      .last      (last),
      .addr_nxt  (addr_nxt),
      .cfg_q     (cfg_q)
   );

   mhf_crc_engine #(
      .POLY      (CRC_POLY),
      .INIT      (CRC_INIT),
      .LSB_FIRST (LSB_FIRST),
      .OUT_BITS  (HASH_BITS)
   ) u_crc (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .step     (take),
      .din      (byte_data),
      .top_bits (hash_idx)
   );

   mhf_verdict #(
      .ADDR_W    (ADDR_W),
      .HASH_BITS (HASH_BITS)
   ) u_verdict (
      .clk        (clk),
      .rst_n      (rst_n),
      .last       (last),
      .addr       (addr_nxt),
      .hash_idx   (hash_idx),
      .promisc    (cfg_q[CFG_W-1]),
      .all_mc     (cfg_q[CFG_W-2]),
      .hash_mc    (cfg_q[CFG_W-3]),
      .station    (cfg_q[TABLE_N +: ADDR_W]),
      .table_bits (cfg_q[TABLE_N-1:0]),
      .dec_vld    (dec_vld),
      .dec_accept (dec_accept)
   );

endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
   parameter int ADDR_BYTES = 6
) (
   input logic       clk,
   input logic       rst_n,
   input logic       sof,
   input logic       byte_vld,
   input logic [7:0] byte_data,
   input logic       mode_promisc,
   input logic       dec_vld,
   input logic       dec_accept
);
   localparam int CW = $clog2(ADDR_BYTES + 1);

   logic [CW-1:0] seen_q;
   logic          promisc_q;
   logic          ones_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q    <= '0;
         promisc_q <= 1'b0;
         ones_q    <= 1'b0;
      end else if (byte_vld && sof) begin
         seen_q    <= CW'(1);
         promisc_q <= mode_promisc;
         ones_q    <= &byte_data;
      end else if (byte_vld && seen_q != '0 && seen_q < CW'(ADDR_BYTES)) begin
         seen_q    <= seen_q + CW'(1);
         ones_q    <= ones_q & (&byte_data);
      end
   end

   a_r2_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |=> !dec_vld);

   a_r2_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_vld |-> !dec_accept);

   a_r2_after_final_byte: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> ($past(byte_vld) && seen_q == CW'(ADDR_BYTES)));

   a_r6_promisc_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && promisc_q) |-> dec_accept);

   a_r7_broadcast_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && ones_q) |-> dec_accept);

endmodule

bind mcast_hash_filter mhf_checker #(.ADDR_BYTES(ADDR_BYTES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sof          (sof),
   .byte_vld     (byte_vld),
   .byte_data    (byte_data),
   .mode_promisc (mode_promisc),
   .dec_vld      (dec_vld),
   .dec_accept   (dec_accept)
);

// File: tb/sim_mcast_hash_filter.sv
module sim_mcast_hash_filter;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sof;
   logic        byte_vld;
   logic [7:0]  byte_data;
   logic        mode_promisc;
   logic        mode_all_mc;
   logic        mode_hash_mc;
   logic [47:0] station_addr;
   logic [63:0] hash_table;
   logic        dec_vld;
   logic        dec_accept;

   int checks = 0;
   int fails  = 0;
   logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

   always #2 clk = ~clk;

   mcast_hash_filter u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .sof          (sof),
      .byte_vld     (byte_vld),
      .byte_data    (byte_data),
      .mode_promisc (mode_promisc),
      .mode_all_mc  (mode_all_mc),
      .mode_hash_mc (mode_hash_mc),
      .station_addr (station_addr),
      .hash_table   (hash_table),
      .dec_vld      (dec_vld),
      .dec_accept   (dec_accept)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [5:0] hash_of(input logic [47:0] a);
      logic [31:0] c;
      logic [7:0]  d;
      logic        fb;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++) begin
         d = a[47 - 8*i -: 8];
         for (int b = 0; b < 8; b++) begin
            fb = c[31] ^ d[b];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C1_1DB7;
         end
      end
      return c[31:26];
   endfunction

   function automatic logic expect_keep(input logic [47:0] a, input logic [2:0] m,
                                        input logic [47:0] st, input logic [63:0] tb);
      if (m[2]) return 1'b1;
      if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
      if (a[40]) return m[1] | (m[0] & tb[hash_of(a)]);
      return a == st;
   endfunction

   task automatic next_rand(output logic [47:0] v);
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 7);
      rs = rs ^ (rs << 17);
      v  = rs[47:0];
   endtask

   // m = {promisc, all_mc, hash_mc}
   task automatic send(input string req, input logic [47:0] a, input logic [2:0] m,
                       input logic [47:0] st, input logic [63:0] tb,
                       input int gap, input bit flip);
      @(negedge clk);
      {mode_promisc, mode_all_mc, mode_hash_mc} = m;
      station_addr = st;
      hash_table   = tb;
      sof = 1'b1; byte_vld = 1'b1; byte_data = a[47:40];
      for (int i = 1; i < 6; i++) begin
         @(negedge clk);
         sof = 1'b0;
         if (flip && i == 1) begin
            {mode_promisc, mode_all_mc, mode_hash_mc} = ~m;
            station_addr = ~st;
            hash_table   = ~tb;
         end
         if (gap > 0) begin
            byte_vld = 1'b0;
            repeat (gap) @(negedge clk);
         end
         if (i == 5) check("R2", "early valid", {63'd0, dec_vld}, 64'd0);
         byte_vld = 1'b1; byte_data = a[47 - 8*i -: 8];
      end
      @(negedge clk);
      byte_vld = 1'b0;
      check("R2", "valid after sixth byte", {63'd0, dec_vld}, 64'd1);
      check(req, "decision", {63'd0, dec_accept}, {63'd0, expect_keep(a, m, st, tb)});
      @(negedge clk);
      check("R2", "pulse width", {63'd0, dec_vld}, 64'd0);
   endtask

   task automatic partial(input logic [47:0] a, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sof = (i == 0); byte_vld = 1'b1; byte_data = a[47 - 8*i -: 8];
      end
      @(negedge clk);
      sof = 1'b0; byte_vld = 1'b0;
   endtask

   task automatic stray(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sof = 1'b0; byte_vld = 1'b1; byte_data = 8'hFF;
         check("R10", "stray byte valid", {63'd0, dec_vld}, 64'd0);
      end
      @(negedge clk);
      byte_vld = 1'b0;
      check("R10", "stray byte valid", {63'd0, dec_vld}, 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   localparam logic [47:0] ST = 48'h02A4_1C39_7E50;

   initial begin
      logic [47:0] a;
      logic [63:0] seen;
      int          draws;
      rst_n = 1'b0; sof = 1'b0; byte_vld = 1'b0; byte_data = '0;
      mode_promisc = 1'b0; mode_all_mc = 1'b0; mode_hash_mc = 1'b0;
      station_addr = '0; hash_table = '0;
      repeat (3) @(negedge clk);
      check("R1", "reset valid", {63'd0, dec_vld}, 64'd0);
      check("R1", "reset accept", {63'd0, dec_accept}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "idle valid", {63'd0, dec_vld}, 64'd0);

      // R3: exact match and every single-bit miss, across all mode combinations
      for (int m = 0; m < 8; m++) begin
         send("R3", ST, 3'(m), ST, 64'h0, 0, 0);
         for (int b = 0; b < 48; b++)
            send("R3", ST ^ (48'd1 << b), 3'(m), ST, 64'h0, 0, 0);
      end

      // R4: sweep until every hash index has been hit
      seen = '0; draws = 0;
      while (seen != '1 && draws < 3000) begin
         next_rand(a);
         a[40] = 1'b1;
         if (a == 48'hFFFF_FFFF_FFFF) a[0] = 1'b0;
         seen[hash_of(a)] = 1'b1;
         send("R4", a, 3'b001, ST, 64'd1 << hash_of(a), 0, 0);
         send("R4", a, 3'b001, ST, ~(64'd1 << hash_of(a)), 0, 0);
         draws++;
      end
      check("R4", "index coverage", seen, '1);

      for (int k = 0; k < 16; k++) begin
         next_rand(a);
         a[40] = 1'b1; a[0] = 1'b0;
         send("R5", a, 3'b010, ST, 64'h0, 0, 0);
         send("R8", a, 3'b000, ST, '1, 0, 0);
         a[40] = 1'b0;
         send("R6", a, 3'b100, ST, 64'h0, 0, 0);
         send("R3", a, 3'b011, ST, '1, k % 3, 0);
      end

      send("R7", 48'hFFFF_FFFF_FFFF, 3'b000, ST, 64'h0, 0, 0);
      send("R7", 48'hFFFF_FFFF_FFFF, 3'b001, ST, 64'h0, 2, 0);

      // R9: configuration changed right after the start byte
      send("R9", ST, 3'b000, ST, 64'h0, 0, 1);
      send("R9", ST ^ 48'h1, 3'b000, ST, 64'h0, 0, 1);
      a = 48'h0100_5E00_0001;
      send("R9", a, 3'b001, ST, 64'd1 << hash_of(a), 0, 1);
      send("R9", a, 3'b001, ST, ~(64'd1 << hash_of(a)), 1, 1);

      // R10: stray bytes and restarts
      stray(3);
      send("R10", ST, 3'b000, ST, 64'h0, 0, 0);
      stray(4);
      partial(ST, 3);
      send("R10", ST ^ 48'h10, 3'b000, ST, 64'h0, 0, 0);
      partial(ST ^ 48'h10, 5);
      send("R10", ST, 3'b000, ST, 64'h0, 0, 0);

      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule